// File: doc/BRIEF.md
# USB Function Address and Endpoint Decoder

This block sits behind the token decoder of a USB device. For every token it receives the device address field, the endpoint field and the token direction. It decides whether the token belongs to this function and, if so, which of seven endpoint FIFO slots takes part in the data stage. Software programs one function address with its own enable bit. For each slot it programs an enable bit, an endpoint number and an isochronous flag. The FIFO storage reports a full flag and an empty flag for each slot.

Slot 0 is the control endpoint, with one small FIFO shared by both directions. Slots 1, 3 and 5 serve IN (transmit) traffic. Slots 2, 4 and 6 serve OUT and SETUP (receive) traffic. All slots are compared at the same time. Several enabled slots of one direction may carry the same endpoint number; in that case the lowest-indexed eligible slot wins. An isochronous slot steps aside when it cannot take part (full for receive, empty for transmit), so two isochronous receive slots that share a number alternate as a ping-pong pair.

The token input is a valid-only stream. There is no ready signal and no back-pressure: a token may be presented on every cycle and each one is decoded. The result is a one-cycle strobe with a hit flag and a slot index. The hit flag and the index stay readable until the next token arrives.

Top module: `usb_ep_decoder`

## Requirements
- R1: `dec_valid` is high for exactly the one cycle after each cycle in which `tok_valid` is high, and is low otherwise.
- R2: A token hits only when `func_addr_en` is 1 and `tok_addr` equals `func_addr`. Any other token gives `dec_valid`=1 with `dec_hit`=0 and `dec_slot`=0.
- R3: When `tok_is_in`=1 (IN token), only slot 0 and slots 1, 3 and 5 are candidates. When `tok_is_in`=0 (OUT or SETUP token), only slot 0 and slots 2, 4 and 6 are candidates. An IN token and an OUT token with the same endpoint number never affect each other.
- R4: A slot is a candidate only when its bit in `slot_en` is 1 and its 4-bit field `slot_epn[4*i+3:4*i]` equals `tok_epn`.
- R5: When more than one candidate qualifies, `dec_slot` is the lowest slot index among them.
- R6: A slot whose `slot_iso` bit is 0 qualifies whatever the state of its `slot_full` and `slot_empty` bits.
- R7: A slot whose `slot_iso` bit is 1 is skipped when its `slot_full` bit is 1 for an OUT token, or when its `slot_empty` bit is 1 for an IN token. The next qualifying slot is then chosen.
- R8: If the address matches but no slot qualifies, the result is `dec_hit`=0 with `dec_slot`=0.
- R9: Between tokens, `dec_hit` and `dec_slot` hold the last result. During reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | Token strobe; one token per high cycle, never stalled |
| tok_is_in | input | 1 | 1 = IN token, 0 = OUT or SETUP token |
| tok_addr | input | 7 | Device address field of the token |
| tok_epn | input | 4 | Endpoint field of the token |
| func_addr | input | 7 | Programmed function address |
| func_addr_en | input | 1 | Enables address decoding |
| slot_en | input | 7 | Per-slot enable, bit i for slot i |
| slot_epn | input | 28 | Per-slot endpoint number, bits 4*i+3:4*i for slot i |
| slot_iso | input | 7 | Per-slot isochronous flag |
| slot_full | input | 7 | Per-slot FIFO full status |
| slot_empty | input | 7 | Per-slot FIFO empty status |
| dec_valid | output | 1 | One-cycle result strobe |
| dec_hit | output | 1 | Token accepted by a slot |
| dec_slot | output | 3 | Index of the selected slot, 0 when no hit |

## Verification
The bench targets endpoint numbers shared within one direction. A design with a wrong priority order would pick a higher slot. A design that lets full or empty status block bulk slots would drop tokens that a busy non-isochronous endpoint should still take. An isochronous pair with its lower slot full must move to the upper slot, and with both full it must miss. A decoder that ignores the direction split would answer an IN token from a receive slot. Other cases check a disabled function address, a one-bit address difference, and result hold across idle cycles. A long sweep over pseudo-random configurations compares every token against a model built from the requirements.

// File: rtl/usb_epdec_pkg.sv
package usb_epdec_pkg;

  // Token direction as seen by the decoder
  typedef enum logic {
    DIR_RX = 1'b0,   // OUT or SETUP
    DIR_TX = 1'b1    // IN
  } tok_dir_e;

  // Slot 0 serves both directions, odd slots transmit, even slots receive
  function automatic bit slot_serves(input int idx, input tok_dir_e dir);
    if (idx == 0) return 1'b1;
    if (dir == DIR_TX) return (idx % 2) == 1;
    return (idx % 2) == 0;
  endfunction

endpackage

// File: rtl/usb_epdec_addr_cmp.sv
module usb_epdec_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] func_addr,
  input  logic              func_addr_en,
  output logic              addr_hit
);

  always_comb begin
    addr_hit = func_addr_en && (tok_addr == func_addr);
  end

endmodule

// File: rtl/usb_epdec_slot_match.sv
module usb_epdec_slot_match
  import usb_epdec_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int EPN_W = 4
) (
  input  logic             en,
  input  logic [EPN_W-1:0] epn,
  input  logic             iso,
  input  logic             full,
  input  logic             empty,
  input  logic [EPN_W-1:0] tok_epn,
  input  tok_dir_e         tok_dir,
  output logic             elig
);

  localparam bit SERVES_TX = slot_serves(IDX, DIR_TX);
  localparam bit SERVES_RX = slot_serves(IDX, DIR_RX);

  logic dir_ok;
  logic busy;

  always_comb begin
    dir_ok = (tok_dir == DIR_TX) ? SERVES_TX : SERVES_RX;
    // an isochronous slot that cannot move data steps aside
    busy   = iso && ((tok_dir == DIR_TX) ? empty : full);
    elig   = en && dir_ok && (epn == tok_epn) && !busy;
  end

endmodule

// File: rtl/usb_epdec_prio.sv
module usb_epdec_prio #(
  parameter int N     = 7,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/usb_ep_decoder.sv
module usb_ep_decoder
  import usb_epdec_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int EPN_W   = 4,
  parameter int N_SLOTS = 7,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tok_valid,
  input  logic                     tok_is_in,
  input  logic [ADDR_W-1:0]        tok_addr,
  input  logic [EPN_W-1:0]         tok_epn,
  input  logic [ADDR_W-1:0]        func_addr,
  input  logic                     func_addr_en,
  input  logic [N_SLOTS-1:0]       slot_en,
  input  logic [N_SLOTS*EPN_W-1:0] slot_epn,
  input  logic [N_SLOTS-1:0]       slot_iso,
  input  logic [N_SLOTS-1:0]       slot_full,
  input  logic [N_SLOTS-1:0]       slot_empty,
  output logic                     dec_valid,
  output logic                     dec_hit,
  output logic [IDX_W-1:0]         dec_slot
);

  tok_dir_e           dir;
  logic               addr_hit;
  logic [N_SLOTS-1:0] elig;
  logic               any_elig;
  logic [IDX_W-1:0]   win_idx;
  logic               take;

  assign dir = tok_is_in ? DIR_TX : DIR_RX;

  usb_epdec_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .tok_addr     (tok_addr),
    .func_addr    (func_addr),
    .func_addr_en (func_addr_en),
    .addr_hit     (addr_hit)
  );

  // all slots compared side by side
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    usb_epdec_slot_match #(.IDX(g), .EPN_W(EPN_W)) u_match (
      .en      (slot_en[g]),
      .epn     (slot_epn[g*EPN_W +: EPN_W]),
      .iso     (slot_iso[g]),
      .full    (slot_full[g]),
      .empty   (slot_empty[g]),
      .tok_epn (tok_epn),
      .tok_dir (dir),
      .elig    (elig[g])
    );
  end

  usb_epdec_prio #(.N(N_SLOTS), .IDX_W(IDX_W)) u_prio (
    .req   (elig),
    .found (any_elig),
    .idx   (win_idx)
  );

  assign take = addr_hit && any_elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_hit   <= 1'b0;
      dec_slot  <= '0;
    end else begin
      dec_valid <= tok_valid;
      if (tok_valid) begin
        dec_hit  <= take;
        dec_slot <= take ? win_idx : '0;
      end
    end
  end

endmodule

// File: rtl/usb_ep_decoder_chk.sv
module usb_ep_decoder_chk #(
  parameter int ADDR_W  = 7,
  parameter int EPN_W   = 4,
  parameter int N_SLOTS = 7,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tok_valid,
  input logic                     tok_is_in,
  input logic [ADDR_W-1:0]        tok_addr,
  input logic [EPN_W-1:0]         tok_epn,
  input logic [ADDR_W-1:0]        func_addr,
  input logic                     func_addr_en,
  input logic [N_SLOTS-1:0]       slot_en,
  input logic [N_SLOTS*EPN_W-1:0] slot_epn,
  input logic                     dec_valid,
  input logic                     dec_hit,
  input logic [IDX_W-1:0]         dec_slot
);

  // snapshot of the configuration seen by the last token
  logic [N_SLOTS-1:0]       en_q;
  logic [N_SLOTS*EPN_W-1:0] epn_q;
  logic [EPN_W-1:0]         tok_epn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      epn_q     <= '0;
      tok_epn_q <= '0;
    end else if (tok_valid) begin
      en_q      <= slot_en;
      epn_q     <= slot_epn;
      tok_epn_q <= tok_epn;
    end
  end

  // R1
  a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> dec_valid);
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !dec_valid);

  // R2
  a_r2_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && (!func_addr_en || tok_addr != func_addr))
      |=> (!dec_hit && dec_slot == '0));

  // R3
  a_r3_in_side: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_is_in) |=> (!dec_hit || dec_slot == '0 || dec_slot[0]));
  a_r3_out_side: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_is_in) |=> (!dec_hit || !dec_slot[0]));

  // R4
  a_r4_enabled_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_hit) |-> ((int'(dec_slot) < N_SLOTS) && en_q[dec_slot]
      && (epn_q[int'(dec_slot)*EPN_W +: EPN_W] == tok_epn_q)));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> ($stable(dec_hit) && $stable(dec_slot)));

endmodule

bind usb_ep_decoder usb_ep_decoder_chk #(
  .ADDR_W(ADDR_W), .EPN_W(EPN_W), .N_SLOTS(N_SLOTS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tok_valid    (tok_valid),
  .tok_is_in    (tok_is_in),
  .tok_addr     (tok_addr),
  .tok_epn      (tok_epn),
  .func_addr    (func_addr),
  .func_addr_en (func_addr_en),
  .slot_en      (slot_en),
  .slot_epn     (slot_epn),
  .dec_valid    (dec_valid),
  .dec_hit      (dec_hit),
  .dec_slot     (dec_slot)
);

// File: tb/sim_usb_ep_decoder.sv
`timescale 1ns/1ps
module sim_usb_ep_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_valid = 1'b0;
  logic        tok_is_in = 1'b0;
  logic [6:0]  tok_addr = '0;
  logic [3:0]  tok_epn = '0;
  logic [6:0]  func_addr = '0;
  logic        func_addr_en = 1'b0;
  logic [6:0]  slot_en = '0;
  logic [27:0] slot_epn = '0;
  logic [6:0]  slot_iso = '0;
  logic [6:0]  slot_full = '0;
  logic [6:0]  slot_empty = '0;
  logic        dec_valid;
  logic        dec_hit;
  logic [2:0]  dec_slot;

  int total = 0;
  int bad = 0;
  logic last_hit = 1'b0;
  logic [2:0] last_slot = '0;

  typedef struct {
    logic       hit;
    logic [2:0] slot;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  usb_ep_decoder u0 (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_is_in(tok_is_in),
    .tok_addr(tok_addr), .tok_epn(tok_epn), .func_addr(func_addr),
    .func_addr_en(func_addr_en), .slot_en(slot_en), .slot_epn(slot_epn),
    .slot_iso(slot_iso), .slot_full(slot_full), .slot_empty(slot_empty),
    .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_slot(dec_slot)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected result written from R2..R8
  task automatic model(input logic is_in, input logic [6:0] a, input logic [3:0] e,
                       output logic h, output logic [2:0] s);
    h = 1'b0;
    s = '0;
    if (func_addr_en && a == func_addr) begin
      for (int i = 6; i >= 0; i--) begin
        bit side, blocked;
        side    = (i == 0) || (is_in ? (i % 2 == 1) : (i % 2 == 0));
        blocked = slot_iso[i] && (is_in ? slot_empty[i] : slot_full[i]);
        if (slot_en[i] && slot_epn[i*4 +: 4] == e && side && !blocked) begin
          h = 1'b1;
          s = 3'(i);
        end
      end
    end
  endtask

  task automatic send(input logic is_in, input logic [6:0] a, input logic [3:0] e,
                      input string tag);
    exp_t x;
    @(negedge clk);
    tok_valid = 1'b1;
    tok_is_in = is_in;
    tok_addr  = a;
    tok_epn   = e;
    model(is_in, a, e, x.hit, x.slot);
    x.tag = tag;
    sb.push_back(x);
    last_hit  = x.hit;
    last_slot = x.slot;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic set_slot(input int i, input logic en, input logic [3:0] e, input logic iso);
    slot_en[i]         = en;
    slot_epn[i*4 +: 4] = e;
    slot_iso[i]        = iso;
  endtask

  task automatic clear_cfg();
    slot_en = '0; slot_epn = '0; slot_iso = '0; slot_full = '0; slot_empty = '0;
  endtask

  // monitor: pops one expectation per result strobe
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected strobe", 1, 0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(dec_hit == x.hit, {x.tag, " hit"}, int'(dec_hit), int'(x.hit));
        check(dec_slot == x.slot, {x.tag, " slot"}, int'(dec_slot), int'(x.slot));
      end
    end
  end

  initial begin : watchdog
    #500000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0 && dec_hit == 1'b0 && dec_slot == 3'd0,
          "R9 reset state", int'({dec_valid, dec_hit, dec_slot}), 0);
    rst_n = 1'b1;

    func_addr = 7'h2A;
    func_addr_en = 1'b1;
    set_slot(0, 1'b1, 4'd0, 1'b0);
    send(1'b0, 7'h2A, 4'd0, "R3 control OUT on slot0");
    send(1'b1, 7'h2A, 4'd0, "R3 control IN on slot0");
    send(1'b0, 7'h2B, 4'd0, "R2 address differs");
    func_addr_en = 1'b0;
    send(1'b0, 7'h2A, 4'd0, "R2 address disabled");
    func_addr_en = 1'b1;

    clear_cfg();
    set_slot(1, 1'b1, 4'd3, 1'b0);
    set_slot(2, 1'b1, 4'd3, 1'b0);
    send(1'b1, 7'h2A, 4'd3, "R3 IN picks transmit slot");
    send(1'b0, 7'h2A, 4'd3, "R3 OUT picks receive slot");
    slot_en[2] = 1'b0;
    send(1'b0, 7'h2A, 4'd3, "R4 disabled slot no match");
    send(1'b0, 7'h2A, 4'd4, "R8 no endpoint match");

    // shared bulk number on receive slots 2 and 4
    clear_cfg();
    set_slot(2, 1'b1, 4'd5, 1'b0);
    set_slot(4, 1'b1, 4'd5, 1'b0);
    send(1'b0, 7'h2A, 4'd5, "R5 lower slot wins");
    slot_full[2] = 1'b1;
    send(1'b0, 7'h2A, 4'd5, "R6 bulk ignores full");
    slot_en[2] = 1'b0;
    send(1'b0, 7'h2A, 4'd5, "R5 next slot after disable");

    // isochronous ping-pong on receive slots 2 and 4
    clear_cfg();
    set_slot(2, 1'b1, 4'd5, 1'b1);
    set_slot(4, 1'b1, 4'd5, 1'b1);
    send(1'b0, 7'h2A, 4'd5, "R7 first iso OUT");
    slot_full[2] = 1'b1;
    send(1'b0, 7'h2A, 4'd5, "R7 second iso OUT");
    slot_full[4] = 1'b1;
    send(1'b0, 7'h2A, 4'd5, "R8 both iso full");
    slot_full[2] = 1'b0;
    send(1'b0, 7'h2A, 4'd5, "R7 back to lower iso");

    // isochronous transmit chain and direction independence
    clear_cfg();
    set_slot(1, 1'b1, 4'd6, 1'b1);
    set_slot(3, 1'b1, 4'd6, 1'b1);
    set_slot(5, 1'b1, 4'd6, 1'b1);
    set_slot(2, 1'b1, 4'd6, 1'b1);
    slot_empty[1] = 1'b1;
    send(1'b1, 7'h2A, 4'd6, "R7 IN skips empty slot1");
    slot_empty[3] = 1'b1;
    send(1'b1, 7'h2A, 4'd6, "R7 IN skips to slot5");
    slot_empty = 7'h7F;
    send(1'b0, 7'h2A, 4'd6, "R3 OUT unaffected by transmit state");
    slot_full[1] = 1'b1;
    send(1'b1, 7'h2A, 4'd6, "R7 IN all empty miss");

    // hold across idle cycles
    set_slot(0, 1'b1, 4'd9, 1'b0);
    send(1'b1, 7'h2A, 4'd9, "R9 setup for hold");
    repeat (4) @(negedge clk);
    check(dec_valid == 1'b0, "R1 strobe one cycle", int'(dec_valid), 0);
    check(dec_hit == last_hit && dec_slot == last_slot, "R9 hold between tokens",
          int'({dec_hit, dec_slot}), int'({last_hit, last_slot}));

    // pseudo-random sweep
    lf = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      if (n % 8 == 0) begin
        slot_en    = lf[6:0];
        slot_iso   = lf[13:7];
        slot_full  = lf[20:14];
        slot_empty = lf[27:21];
        for (int i = 0; i < 7; i++) slot_epn[i*4 +: 4] = {2'b00, lf[i % 4 +: 2]};
        lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      end
      send(lf[0], lf[1] ? 7'h2A : lf[8:2], {2'b00, lf[10:9]}, "R5 sweep");
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R1 all results seen", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule